// File: doc/BRIEF.md
# Stack Pointer Offset Folding Unit

This unit sits in the rename stage of a processor front end. Micro-ops that change the stack pointer implicitly (push, pop, call, return) do not become separate add micro-ops. The unit keeps a small signed running offset instead, and the real pointer value is the stored architectural pointer plus that offset. Memory operands that address through the stack pointer are rewritten so their displacement already includes the pending offset. The stream therefore carries on without waiting for the pointer to be updated.

The unit must bring the architectural pointer up to date in only a few cases. These are a micro-op that reads the pointer explicitly while the offset is nonzero, and an update that would push the offset out of its signed range. In those cases it first emits a synchronization micro-op that carries the offset, zeroes the offset, and holds the triggering micro-op back by one cycle. An explicit pointer write makes the pending offset meaningless, so it simply drops it. A flush drops both the offset and any micro-op waiting at the output. The output is a single register stage with a valid/ready handshake.

Top module: `spd_tracker`

## Requirements
- R1: After reset the output is empty (outValid low), the offset is 0, and inReady is high whenever inKind is not an explicit read.
- R2: A push (inKind 1) or call (inKind 3) lowers the offset by STEP (4), and each such micro-op yields exactly one output micro-op. The output keeps the input's kind and tag.
- R3: A pop (inKind 2) or return (inKind 4) raises the offset by STEP and yields exactly one output micro-op.
- R4: When inSpMem is high, outDisp equals inDisp plus the sign-extended offset as it stood before that micro-op's own update, modulo 2^DISP_W.
- R5: An explicit read (inKind 5) that arrives while the offset is nonzero is preceded by a sync micro-op. The sync has outKind 7, outDisp equal to the sign-extended offset, and outTag equal to the trigger's tag. In the cycle the sync is loaded, inReady is low, and the offset becomes 0.
- R6: An explicit read while the offset is 0 passes through with no sync micro-op.
- R7: An explicit write (inKind 6) clears the offset to 0 without emitting a sync micro-op.
- R8: If a push, call, pop or return would take the offset outside the signed DELTA_W-bit range, a sync micro-op carrying the current offset is emitted first. The micro-op is then applied to an offset of 0.
- R9: While outValid is high and outReady is low, the output fields stay stable and inReady is low.
- R10: A flush clears the offset and the output register in the same edge, and inReady is low during the flush.
- R11: Micro-ops with inSpMem low (inKind 0, or any other kind) keep their displacement unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush; drops offset and pending output |
| inValid | input | 1 | Input micro-op valid |
| inReady | output | 1 | Unit accepts the input micro-op this cycle |
| inKind | input | 3 | 0 other, 1 push, 2 pop, 3 call, 4 return, 5 explicit read, 6 explicit write |
| inSpMem | input | 1 | Memory operand addresses through the stack pointer |
| inDisp | input | DISP_W | Memory displacement |
| inTag | input | TAG_W | Micro-op identifier |
| outValid | output | 1 | Output micro-op valid |
| outReady | input | 1 | Downstream accepts the output micro-op |
| outKind | output | 3 | Input kind, or 7 for a sync micro-op |
| outDisp | output | DISP_W | Rewritten displacement, or offset for a sync |
| outTag | output | TAG_W | Tag of the micro-op, or of the trigger for a sync |

## Verification
The bench drives the offset to both range limits. A design that checked the limit off by one step would either wrap the offset silently or emit a sync one push early. It sends an explicit read twice in a row: a unit that did not zero the offset after the sync would emit a second sync, and one that let the read through in the sync cycle would lose ordering. Memory operands issued right after pushes expose an adder that applies the post-update offset. An explicit write followed by a read, and a flush followed by a read, expose a unit that syncs a stale offset. Stretches with outReady low catch an output register that changes, or an input that is accepted, while downstream is stalled.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_PUSH  = 3'd1,
    K_POP   = 3'd2,
    K_CALL  = 3'd3,
    K_RET   = 3'd4,
    K_SPRD  = 3'd5,
    K_SPWR  = 3'd6,
    K_SYNC  = 3'd7
  } uopKind_e;

  typedef enum logic [1:0] {
    D_HOLD = 2'd0,
    D_ZERO = 2'd1,
    D_DEC  = 2'd2,
    D_INC  = 2'd3
  } deltaOp_e;

  typedef struct packed {
    logic     flushAll;
    logic     loadSync;
    logic     loadUop;
    logic     dropOut;
    deltaOp_e deltaOp;
  } strobes_t;

endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic       flush,
  input  logic       inValid,
  input  logic [2:0] inKind,
  input  logic       outValid,
  input  logic       outReady,
  input  logic       deltaZero,
  input  logic       decWouldOvf,
  input  logic       incWouldOvf,
  output logic       inReady,
  output strobes_t   st
);

  uopKind_e kind;
  logic     slotFree;
  logic     isDec;
  logic     isInc;
  logic     needSync;

  always_comb begin
    kind     = uopKind_e'(inKind);
    slotFree = !outValid || outReady;
    isDec    = (kind == K_PUSH) || (kind == K_CALL);
    isInc    = (kind == K_POP)  || (kind == K_RET);
    needSync = ((kind == K_SPRD) && !deltaZero) ||
               (isDec && decWouldOvf) ||
               (isInc && incWouldOvf);
    inReady  = !flush && slotFree && !needSync;
  end

  always_comb begin
    st          = '0;
    st.deltaOp  = D_HOLD;
    if (flush) begin
      st.flushAll = 1'b1;
      st.deltaOp  = D_ZERO;
    end else if (inValid && slotFree && needSync) begin
      st.loadSync = 1'b1;
      st.deltaOp  = D_ZERO;
    end else if (inValid && inReady) begin
      st.loadUop = 1'b1;
      if (isDec)                                  st.deltaOp = D_DEC;
      else if (isInc)                             st.deltaOp = D_INC;
      else if (kind == K_SPWR || kind == K_SPRD)  st.deltaOp = D_ZERO;
      else                                        st.deltaOp = D_HOLD;
    end else if (outValid && outReady) begin
      st.dropOut = 1'b1;
    end
  end

endmodule

// File: rtl/spd_dp.sv
module spd_dp
  import spd_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int DISP_W  = 16,
  parameter int TAG_W   = 6,
  parameter int STEP    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  strobes_t                  st,
  input  logic [2:0]                inKind,
  input  logic                      inSpMem,
  input  logic [DISP_W-1:0]         inDisp,
  input  logic [TAG_W-1:0]          inTag,
  output logic                      outValid,
  output logic [2:0]                outKind,
  output logic [DISP_W-1:0]         outDisp,
  output logic [TAG_W-1:0]          outTag,
  output logic signed [DELTA_W-1:0] spDelta,
  output logic                      deltaZero,
  output logic                      decWouldOvf,
  output logic                      incWouldOvf
);

  localparam int SUM_W = DELTA_W + 1;
  localparam int EXT_W = DISP_W - DELTA_W;

  logic [SUM_W-1:0]  deltaWide;
  logic [SUM_W-1:0]  decSum;
  logic [SUM_W-1:0]  incSum;
  logic [DISP_W-1:0] deltaExt;
  logic [DISP_W-1:0] dispAdj;

  always_comb begin
    deltaWide   = {spDelta[DELTA_W-1], spDelta};
    decSum      = deltaWide - SUM_W'(STEP);
    incSum      = deltaWide + SUM_W'(STEP);
    decWouldOvf = decSum[SUM_W-1] != decSum[DELTA_W-1];
    incWouldOvf = incSum[SUM_W-1] != incSum[DELTA_W-1];
    deltaZero   = (spDelta == '0);
    deltaExt    = {{EXT_W{spDelta[DELTA_W-1]}}, spDelta};
    dispAdj     = inSpMem ? (inDisp + deltaExt) : inDisp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spDelta <= '0;
    end else begin
      case (st.deltaOp)
        D_ZERO:  spDelta <= '0;
        D_DEC:   spDelta <= decSum[DELTA_W-1:0];
        D_INC:   spDelta <= incSum[DELTA_W-1:0];
        default: spDelta <= spDelta;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outKind  <= '0;
      outDisp  <= '0;
      outTag   <= '0;
    end else if (st.flushAll) begin
      outValid <= 1'b0;
    end else if (st.loadSync) begin
      outValid <= 1'b1;
      outKind  <= K_SYNC;
      outDisp  <= deltaExt;
      outTag   <= inTag;
    end else if (st.loadUop) begin
      outValid <= 1'b1;
      outKind  <= inKind;
      outDisp  <= dispAdj;
      outTag   <= inTag;
    end else if (st.dropOut) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/spd_tracker.sv
module spd_tracker
  import spd_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int DISP_W  = 16,
  parameter int TAG_W   = 6,
  parameter int STEP    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inKind,
  input  logic              inSpMem,
  input  logic [DISP_W-1:0] inDisp,
  input  logic [TAG_W-1:0]  inTag,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outKind,
  output logic [DISP_W-1:0] outDisp,
  output logic [TAG_W-1:0]  outTag
);

  strobes_t                  st;
  logic signed [DELTA_W-1:0] spDelta;
  logic                      deltaZero;
  logic                      decWouldOvf;
  logic                      incWouldOvf;

  spd_ctrl u_ctrl (
    .flush       (flush),
    .inValid     (inValid),
    .inKind      (inKind),
    .outValid    (outValid),
    .outReady    (outReady),
    .deltaZero   (deltaZero),
    .decWouldOvf (decWouldOvf),
    .incWouldOvf (incWouldOvf),
    .inReady     (inReady),
    .st          (st)
  );

  spd_dp #(
    .DELTA_W (DELTA_W),
    .DISP_W  (DISP_W),
    .TAG_W   (TAG_W),
    .STEP    (STEP)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .inKind      (inKind),
    .inSpMem     (inSpMem),
    .inDisp      (inDisp),
    .inTag       (inTag),
    .outValid    (outValid),
    .outKind     (outKind),
    .outDisp     (outDisp),
    .outTag      (outTag),
    .spDelta     (spDelta),
    .deltaZero   (deltaZero),
    .decWouldOvf (decWouldOvf),
    .incWouldOvf (incWouldOvf)
  );

endmodule

// File: rtl/spd_checker.sv
module spd_checker
  import spd_pkg::*;
#(
  parameter int DELTA_W = 8,
  parameter int DISP_W  = 16,
  parameter int TAG_W   = 6,
  parameter int STEP    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      flush,
  input logic                      inValid,
  input logic                      inReady,
  input logic [2:0]                inKind,
  input logic                      outValid,
  input logic                      outReady,
  input logic [2:0]                outKind,
  input logic [DISP_W-1:0]         outDisp,
  input logic [TAG_W-1:0]          outTag,
  input logic signed [DELTA_W-1:0] spDelta,
  input strobes_t                  st
);

  // R5: a loaded sync carries a nonzero offset
  a_r5_sync_carries_delta: assert property (@(posedge clk) disable iff (rst)
    st.loadSync |=> (outValid && outKind == 3'd7 && outDisp != '0));

  // R5: the trigger is not accepted in the sync cycle
  a_r5_hold_trigger: assert property (@(posedge clk) disable iff (rst)
    st.loadSync |-> !inReady);

  // R6: an accepted explicit read always sees a zero offset
  a_r6_read_at_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inKind == 3'd5) |-> (spDelta == '0));

  // R9: stalled output holds its fields
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady && !flush) |=>
      (outValid && $stable(outKind) && $stable(outDisp) && $stable(outTag)));

  // R10: flush empties the output and clears the offset
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!outValid && spDelta == '0));

  // R2 / R3: the offset moves only by one step or to zero
  a_r2_delta_steps: assert property (@(posedge clk) disable iff (rst)
    (spDelta != $past(spDelta)) |->
      (spDelta == '0 || int'(spDelta) == int'($past(spDelta)) + STEP ||
       int'(spDelta) == int'($past(spDelta)) - STEP));

endmodule

bind spd_tracker spd_checker #(
  .DELTA_W (DELTA_W),
  .DISP_W  (DISP_W),
  .TAG_W   (TAG_W),
  .STEP    (STEP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .flush    (flush),
  .inValid  (inValid),
  .inReady  (inReady),
  .inKind   (inKind),
  .outValid (outValid),
  .outReady (outReady),
  .outKind  (outKind),
  .outDisp  (outDisp),
  .outTag   (outTag),
  .spDelta  (spDelta),
  .st       (st)
);

// File: tb/spd_tracker_tb.sv
module spd_tracker_tb;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  inKind = 3'd0;
  logic        inSpMem = 1'b0;
  logic [15:0] inDisp = '0;
  logic [5:0]  inTag = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [2:0]  outKind;
  logic [15:0] outDisp;
  logic [5:0]  outTag;

  int checks = 0;
  int fails  = 0;
  int mDelta = 0;
  logic [2:0]  qKind[$];
  logic [15:0] qDisp[$];
  logic [5:0]  qTag[$];
  string       qReq[$];
  bit          prevHeld = 0;
  logic [2:0]  pKind;
  logic [15:0] pDisp;
  logic [5:0]  pTag;
  bit          lastFire;
  logic [5:0]  tagCnt = 6'd1;

  spd_tracker u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .inValid(inValid), .inReady(inReady), .inKind(inKind),
    .inSpMem(inSpMem), .inDisp(inDisp), .inTag(inTag),
    .outValid(outValid), .outReady(outReady),
    .outKind(outKind), .outDisp(outDisp), .outTag(outTag)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic bit needSync(int d, int k);
    if (k == 5) return d != 0;
    if (k == 1 || k == 3) return (d - 4) < -128;
    if (k == 2 || k == 4) return (d + 4) > 127;
    return 0;
  endfunction

  function automatic int nextDelta(int d, int k);
    if (k == 1 || k == 3) return d - 4;
    if (k == 2 || k == 4) return d + 4;
    if (k == 5 || k == 6) return 0;
    return d;
  endfunction

  function automatic logic [15:0] adjDisp(logic [15:0] disp, bit m, int d);
    return m ? disp + 16'(d) : disp;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, int k, bit m, logic [15:0] d, logic [5:0] t, bit rdy, bit fl);
    bit slotFree;
    bit expReady;
    @(negedge clk);
    inValid = v; inKind = 3'(k); inSpMem = m; inDisp = d; inTag = t;
    outReady = fl ? 1'b0 : rdy; flush = fl;
    #(PERIOD/4);
    lastFire = 0;
    if (prevHeld) begin
      check(outValid == 1'b1 && outKind == pKind && outDisp == pDisp && outTag == pTag,
            "R9", "stalled output changed", int'(outDisp), int'(pDisp));
    end
    if (fl) begin
      check(inReady == 1'b0, "R10", "inReady during flush", int'(inReady), 0);
      qKind.delete(); qDisp.delete(); qTag.delete(); qReq.delete();
      mDelta = 0;
      prevHeld = 0;
      return;
    end
    slotFree = !outValid || outReady;
    if (outValid && outReady) begin
      if (qKind.size() == 0) begin
        check(0, "R2", "unexpected output uop", int'(outTag), -1);
      end else begin
        check(outKind == qKind[0], qReq[0], "outKind", int'(outKind), int'(qKind[0]));
        check(outDisp == qDisp[0], qReq[0], "outDisp", int'(outDisp), int'(qDisp[0]));
        check(outTag == qTag[0], qReq[0], "outTag", int'(outTag), int'(qTag[0]));
        void'(qKind.pop_front()); void'(qDisp.pop_front());
        void'(qTag.pop_front()); void'(qReq.pop_front());
      end
    end
    expReady = slotFree && !needSync(mDelta, k);
    check(inReady == expReady, outValid && !outReady ? "R9" : "R5", "inReady",
          int'(inReady), int'(expReady));
    if (v && slotFree) begin
      if (needSync(mDelta, k)) begin
        qKind.push_back(3'd7); qDisp.push_back(16'(mDelta)); qTag.push_back(t);
        qReq.push_back(k == 5 ? "R5" : "R8");
        mDelta = 0;
      end else begin
        qKind.push_back(3'(k)); qDisp.push_back(adjDisp(d, m, mDelta)); qTag.push_back(t);
        qReq.push_back(m ? "R4" : (k == 6 ? "R7" : (k == 5 ? "R6" : "R11")));
        mDelta = nextDelta(mDelta, k);
        lastFire = 1;
      end
    end
    prevHeld = outValid && !outReady;
    pKind = outKind; pDisp = outDisp; pTag = outTag;
  endtask

  task automatic send(int k, bit m, logic [15:0] d);
    for (int i = 0; i < 10; i++) begin
      step(1, k, m, d, tagCnt, 1, 0);
      if (lastFire) break;
    end
    tagCnt = tagCnt + 6'd1;
  endtask

  task automatic drain();
    for (int i = 0; i < 20; i++) begin
      if (qKind.size() == 0 && !outValid) break;
      step(0, 0, 0, '0, '0, 1, 0);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL R9 watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #(PERIOD/4);
    check(outValid == 1'b0, "R1", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    // R1 / R6: a read right after reset needs no sync
    send(5, 0, 16'd0);
    send(0, 1, 16'd20);          // R11 / R4 with zero offset
    // R2 / R4: pushes then a stack-relative load
    send(1, 1, 16'd0); send(1, 0, 16'd0); send(3, 0, 16'd0);
    send(0, 1, 16'd16);          // expect 16 - 12 = 4
    send(5, 0, 16'd0);           // R5: sync carrying -12
    send(5, 0, 16'd0);           // R6: no second sync
    // R3: pops and returns raise the offset
    send(2, 0, 16'd0); send(4, 1, 16'd8);
    send(5, 0, 16'd0);           // R5: sync carrying 8
    // R7: explicit write drops the offset
    send(1, 0, 16'd0); send(1, 0, 16'd0); send(6, 0, 16'd0);
    send(5, 0, 16'd0);
    // R8: underflow limit
    for (int i = 0; i < 32; i++) send(1, 0, 16'd0);
    send(1, 1, 16'd0);           // sync -128 first, then push at 0
    send(5, 0, 16'd0);           // sync -4
    // R8: overflow limit
    for (int i = 0; i < 31; i++) send(2, 0, 16'd0);
    send(4, 0, 16'd0);           // sync 124 first
    send(5, 0, 16'd0);           // sync 4
    drain();
    // R9: downstream stall
    step(1, 1, 0, 16'd0, 6'd40, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 2, 0, 16'd0, 6'd41, 0, 0);
    drain();
    // R10: flush drops offset and pending output
    send(1, 0, 16'd0); send(1, 0, 16'd0);
    step(0, 0, 0, 16'd0, 6'd0, 0, 1);
    send(5, 0, 16'd0);
    drain();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int k;
      bit fl;
      k  = int'($urandom % 8);
      if (k == 7) k = 0;
      fl = ($urandom % 64) == 0;
      step(($urandom % 4) != 0 && !fl, k, 1'($urandom), 16'($urandom), 6'($urandom),
           ($urandom % 4) != 0, fl);
    end
    drain();
    check(qKind.size() == 0, "R2", "leftover expected uops", qKind.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule